// File: doc/BRIEF.md
# Keyboard Controller Host Register Interface

This block is the host-facing side of a keyboard and pointing-device controller. It has two byte-wide I/O ports. One is a data port at address 60h. The other is a command/status port at address 64h. A host write to either port lands in a one-byte input buffer. A small sequencer drains that buffer one clock later. Writes to the command port are decoded as controller commands. A data-port write reaches the configuration register only when the previous command asked for it. Reading the command/status port returns a status byte and changes nothing.

Bytes arriving from the keyboard or mouse side are offered on a simple valid/ready port. The block places them in a one-byte output buffer and remembers which device supplied each one. It raises the matching interrupt line when that device's interrupt is enabled. Timeout and parity errors are pulsed in from the device side and held as sticky status flags. The serial line protocol and scan-code translation are handled elsewhere.

Top module: `kbc_host_if`

## Requirements
- R1: After a synchronous reset, the output and input buffers are empty, both error flags are clear, the command-written flag is clear and the configuration byte is 00h. The status byte then reads 10h while `kbd_inhibit_n` is 1.
- R2: An accepted host write to 60h or 64h sets input-full (status bit 1) for exactly the next cycle. A host write made while input-full is 1 is dropped with no effect.
- R3: Status bits, from bit 0 to bit 7, are as follows:
  - bit 0: output full.
  - bit 1: input full.
  - bit 2: system flag, equal to configuration bit 2.
  - bit 3: last accepted write was to 64h (1) or to 60h (0).
  - bit 4: equal to `kbd_inhibit_n` (0 means inhibited).
  - bit 5: output full with a mouse byte.
  - bit 6: timeout flag.
  - bit 7: parity flag.
- R4: Reading port 64h returns the status byte and alters no state.
- R5: Command 20h copies the configuration byte into the output buffer and sets output-full, in the same cycle that input-full clears.
- R6: Command 60h arms the sequencer. The next accepted data-port write replaces the configuration byte and disarms it. Configuration bits are: 0 keyboard interrupt enable, 1 mouse interrupt enable, 2 system flag, 4 keyboard disable, 5 mouse disable, 6 translate. Bits 3 and 7 are reserved and are stored as written.
- R7: Command A7h sets configuration bit 5. Command A8h clears it.
- R8: A host read of 60h returns the output buffer byte and clears output-full and the mouse-full bit. The byte itself is kept.
- R9: A device byte is accepted only when the output buffer is empty, no command response is being loaded, and the sending device is not disabled (bit 4 for the keyboard, bit 5 for the mouse). `dev_ready` shows this condition for the current `dev_is_mouse`. A held buffer is never overwritten by a device byte.
- R10: `kbd_irq` is high while a non-mouse byte is held and configuration bit 0 is 1. `mouse_irq` is high while a mouse byte is held and bit 1 is 1. The two lines are never high together.
- R11: A one-cycle pulse on `dev_timeout` or `dev_parity` sets the matching status flag. The flag stays set until the host reads port 60h.
- R12: Commands other than 20h, 60h, A7h and A8h have no effect. A data-port write while not armed has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | Host I/O address |
| io_rd | input | 1 | Host read strobe, one cycle per read |
| io_wr | input | 1 | Host write strobe, one cycle per write |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data (status at 64h, output buffer at 60h, else 00h) |
| dev_valid | input | 1 | Device byte offered |
| dev_is_mouse | input | 1 | Offered byte comes from the mouse |
| dev_data | input | 8 | Offered device byte |
| dev_ready | output | 1 | Offered byte will be taken at the next edge |
| dev_timeout | input | 1 | Timeout error pulse |
| dev_parity | input | 1 | Parity error pulse |
| kbd_inhibit_n | input | 1 | Keyboard inhibit switch, 0 = inhibited |
| kbd_irq | output | 1 | Keyboard interrupt request |
| mouse_irq | output | 1 | Mouse interrupt request |

## Verification
The assertions assume each host access lasts one cycle, with `io_rd` and `io_wr` never asserted together. They also assume the device side drops `dev_valid` once the byte is taken. Under those conditions, a held input byte is always consumed on the very next edge, and the output buffer changes only through a load or a read. The stimulus issues every host access as a single-cycle strobe. It offers device bytes for exactly one edge and pulses error inputs for one cycle. It provokes a dropped write only by writing twice in consecutive cycles.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

    typedef logic [7:0] byte_t;

    localparam byte_t CMD_RD_CFG  = 8'h20;
    localparam byte_t CMD_WR_CFG  = 8'h60;
    localparam byte_t CMD_AUX_OFF = 8'hA7;
    localparam byte_t CMD_AUX_ON  = 8'hA8;

    typedef struct packed {
        logic rsvd7;
        logic xlate;
        logic mouse_dis;
        logic kbd_dis;
        logic rsvd3;
        logic sys_flag;
        logic mouse_ie;
        logic kbd_ie;
    } cfg_t;

    typedef struct packed {
        logic parity_err;
        logic timeout_err;
        logic aux_full;
        logic not_inhibited;
        logic last_cmd;
        logic sys_flag;
        logic in_full;
        logic out_full;
    } status_t;

    typedef enum logic {SRC_KBD = 1'b0, SRC_AUX = 1'b1} src_e;

    localparam int unsigned ERR_TIMEOUT = 0;
    localparam int unsigned ERR_PARITY  = 1;
    localparam int unsigned N_ERR       = 2;

    function automatic logic src_blocked(src_e src, cfg_t cfg);
        return (src == SRC_AUX) ? cfg.mouse_dis : cfg.kbd_dis;
    endfunction

endpackage

// File: rtl/kbc_cmd_seq.sv
module kbc_cmd_seq
    import kbc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  host_wr,
    input  logic  host_is_cmd,
    input  byte_t host_wdata,
    output logic  ibf,
    output logic  last_cmd,
    output cfg_t  cfg,
    output logic  resp_load,
    output byte_t resp_data
);

    byte_t ibuf_q;
    logic  ibuf_cmd_q;
    logic  armed_q;
    logic  wr_acc;

    assign wr_acc    = host_wr && !ibf;
    assign resp_load = ibf && ibuf_cmd_q && (ibuf_q == CMD_RD_CFG);
    assign resp_data = byte_t'(cfg);

    always_ff @(posedge clk) begin
        if (rst) begin
            ibf        <= 1'b0;
            ibuf_q     <= '0;
            ibuf_cmd_q <= 1'b0;
            last_cmd   <= 1'b0;
            armed_q    <= 1'b0;
            cfg        <= '0;
        end else begin
            ibf <= wr_acc;
            if (wr_acc) begin
                ibuf_q     <= host_wdata;
                ibuf_cmd_q <= host_is_cmd;
                last_cmd   <= host_is_cmd;
            end
            if (ibf) begin
                if (ibuf_cmd_q) begin
                    armed_q <= (ibuf_q == CMD_WR_CFG);
                    unique case (ibuf_q)
                        CMD_AUX_OFF: cfg.mouse_dis <= 1'b1;
                        CMD_AUX_ON:  cfg.mouse_dis <= 1'b0;
                        default:     ;
                    endcase
                end else if (armed_q) begin
                    cfg     <= cfg_t'(ibuf_q);
                    armed_q <= 1'b0;
                end
            end
        end
    end

    // R2: a held input byte is always drained on the next edge
    p_in_full_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        ibf |=> !ibf);

    // R6: an armed data byte becomes the configuration byte
    p_armed_store_r6: assert property (@(posedge clk) disable iff (rst)
        (ibf && !ibuf_cmd_q && armed_q) |=> (byte_t'(cfg) == $past(ibuf_q)));

    // R7: aux-off command sets the mouse disable bit
    p_aux_off_r7: assert property (@(posedge clk) disable iff (rst)
        (ibf && ibuf_cmd_q && ibuf_q == CMD_AUX_OFF) |=> cfg.mouse_dis);

    // R12: data with no arming leaves configuration untouched
    p_unarmed_ignored_r12: assert property (@(posedge clk) disable iff (rst)
        (ibf && !ibuf_cmd_q && !armed_q) |=> $stable(cfg));

endmodule

// File: rtl/kbc_obuf.sv
module kbc_obuf
    import kbc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  resp_load,
    input  byte_t resp_data,
    input  logic  dev_valid,
    input  logic  dev_is_mouse,
    input  byte_t dev_data,
    input  cfg_t  cfg,
    input  logic  host_rd,
    output logic  obf,
    output src_e  src,
    output byte_t data,
    output logic  dev_ready
);

    src_e dev_src;
    logic dev_acc;

    assign dev_src   = dev_is_mouse ? SRC_AUX : SRC_KBD;
    assign dev_ready = !obf && !resp_load && !src_blocked(dev_src, cfg);
    assign dev_acc   = dev_valid && dev_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            obf  <= 1'b0;
            src  <= SRC_KBD;
            data <= '0;
        end else if (resp_load) begin
            obf  <= 1'b1;
            src  <= SRC_KBD;
            data <= resp_data;
        end else if (dev_acc) begin
            obf  <= 1'b1;
            src  <= dev_src;
            data <= dev_data;
        end else if (host_rd) begin
            obf  <= 1'b0;
            src  <= SRC_KBD;
        end
    end

    // R8: a host data read with no new load empties the buffer
    p_read_empties_r8: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !resp_load && !(dev_valid && dev_ready)) |=> !obf);

    // R9: a full buffer is never overwritten by the device side
    p_hold_while_full_r9: assert property (@(posedge clk) disable iff (rst)
        (obf && !host_rd && !resp_load) |=> (obf && $stable(data)));

    // R5: a command response always fills the buffer
    p_resp_fills_r5: assert property (@(posedge clk) disable iff (rst)
        resp_load |=> (obf && src == SRC_KBD));

endmodule

// File: rtl/kbc_err_flags.sv
module kbc_err_flags #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)         q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (clr)    q[i] <= 1'b0;
        end

        // R11: a flag persists until the clearing read
        p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
            (q[i] && !clr) |=> q[i]);
    end

endmodule

// File: rtl/kbc_host_if.sv
module kbc_host_if
    import kbc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_PORT = 'h60,
    parameter int unsigned CMD_PORT  = 'h64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              dev_valid,
    input  logic              dev_is_mouse,
    input  logic [7:0]        dev_data,
    output logic              dev_ready,
    input  logic              dev_timeout,
    input  logic              dev_parity,
    input  logic              kbd_inhibit_n,
    output logic              kbd_irq,
    output logic              mouse_irq
);

    localparam logic [ADDR_W-1:0] A_DATA = DATA_PORT[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_CMD  = CMD_PORT[ADDR_W-1:0];

    logic        sel_data, sel_cmd;
    logic        host_wr, host_rd_data;
    logic        ibf, last_cmd, resp_load, obf;
    cfg_t        cfg;
    byte_t       resp_data, ob_data;
    src_e        ob_src;
    logic [N_ERR-1:0] err_set, err_q;
    status_t     status;

    assign sel_data     = (io_addr == A_DATA);
    assign sel_cmd      = (io_addr == A_CMD);
    assign host_wr      = io_wr && (sel_data || sel_cmd);
    assign host_rd_data = io_rd && sel_data;

    kbc_cmd_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .host_wr     (host_wr),
        .host_is_cmd (sel_cmd),
        .host_wdata  (io_wdata),
        .ibf         (ibf),
        .last_cmd    (last_cmd),
        .cfg         (cfg),
        .resp_load   (resp_load),
        .resp_data   (resp_data)
    );

    kbc_obuf u_obuf (
        .clk          (clk),
        .rst          (rst),
        .resp_load    (resp_load),
        .resp_data    (resp_data),
        .dev_valid    (dev_valid),
        .dev_is_mouse (dev_is_mouse),
        .dev_data     (dev_data),
        .cfg          (cfg),
        .host_rd      (host_rd_data),
        .obf          (obf),
        .src          (ob_src),
        .data         (ob_data),
        .dev_ready    (dev_ready)
    );

    always_comb begin
        err_set              = '0;
        err_set[ERR_TIMEOUT] = dev_timeout;
        err_set[ERR_PARITY]  = dev_parity;
    end

    kbc_err_flags #(.N(N_ERR)) u_err (
        .clk (clk),
        .rst (rst),
        .set (err_set),
        .clr (host_rd_data),
        .q   (err_q)
    );

    always_comb begin
        status.out_full      = obf;
        status.in_full       = ibf;
        status.sys_flag      = cfg.sys_flag;
        status.last_cmd      = last_cmd;
        status.not_inhibited = kbd_inhibit_n;
        status.aux_full      = obf && (ob_src == SRC_AUX);
        status.timeout_err   = err_q[ERR_TIMEOUT];
        status.parity_err    = err_q[ERR_PARITY];
    end

    always_comb begin
        if (sel_cmd)       io_rdata = byte_t'(status);
        else if (sel_data) io_rdata = ob_data;
        else               io_rdata = '0;
    end

    assign kbd_irq   = obf && (ob_src == SRC_KBD) && cfg.kbd_ie;
    assign mouse_irq = obf && (ob_src == SRC_AUX) && cfg.mouse_ie;

    // R10: only one interrupt source at a time
    p_irq_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        !(kbd_irq && mouse_irq));

    // R4: a status read on its own changes neither buffer
    p_status_read_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (io_rd && sel_cmd && !io_wr && !ibf && !dev_valid) |=> ($stable(obf) && !ibf));

endmodule

// File: tb/kbc_host_if_bench.sv
module kbc_host_if_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] P_DATA = 16'h0060;
    localparam logic [15:0] P_CMD  = 16'h0064;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] io_addr;
    logic        io_rd, io_wr;
    logic [7:0]  io_wdata, io_rdata;
    logic        dev_valid, dev_is_mouse;
    logic [7:0]  dev_data;
    logic        dev_ready, dev_timeout, dev_parity, kbd_inhibit_n;
    logic        kbd_irq, mouse_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    kbc_host_if u_kbc_host_if (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_valid(dev_valid),
        .dev_is_mouse(dev_is_mouse), .dev_data(dev_data), .dev_ready(dev_ready),
        .dev_timeout(dev_timeout), .dev_parity(dev_parity),
        .kbd_inhibit_n(kbd_inhibit_n), .kbd_irq(kbd_irq), .mouse_irq(mouse_irq)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // monitor: compares every data-port read against the scoreboard
    always @(negedge clk) begin
        if (!rst && io_rd && io_addr == P_DATA) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R8: actual %02h expected <none queued>", io_rdata);
            end else begin
                check(io_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic host_write(input logic [15:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        tick();
        io_wr = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        io_addr = P_DATA; io_rd = 1'b1;
        tick();
        io_rd = 1'b0;
    endtask

    task automatic peek(output logic [7:0] s);
        io_addr = P_CMD; io_rd = 1'b1;
        #1 s = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic dev_send(input logic mouse, input logic [7:0] d,
                            input logic exp_ready, input string tag);
        dev_valid = 1'b1; dev_is_mouse = mouse; dev_data = d;
        #1 check({7'd0, dev_ready}, {7'd0, exp_ready}, tag);
        tick();
        dev_valid = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] s, s2;
        rst = 1'b1; io_addr = '0; io_rd = 0; io_wr = 0; io_wdata = '0;
        dev_valid = 0; dev_is_mouse = 0; dev_data = '0;
        dev_timeout = 0; dev_parity = 0; kbd_inhibit_n = 1;
        repeat (3) tick();
        rst = 1'b0;

        peek(s); check(s, 8'h10, "R1 reset status");
        check({7'd0, kbd_irq}, 8'h00, "R1 reset irq");

        // read configuration
        host_write(P_CMD, 8'h20);
        peek(s); check(s & 8'h0B, 8'h0A, "R2 R3 input full and cmd flag");
        tick();
        peek(s); check(s & 8'h03, 8'h01, "R5 response fills output");
        host_read(8'h00, "R5 reset config byte");
        peek(s); check(s & 8'h01, 8'h00, "R8 read clears output full");

        // write configuration
        host_write(P_CMD, 8'h60); tick();
        host_write(P_DATA, 8'h47); tick();
        peek(s); check(s & 8'h0C, 8'h04, "R6 R3 system flag, data flag");
        host_write(P_CMD, 8'h20); tick();
        host_read(8'h47, "R6 stored config");

        // dropped write, aux off/on
        host_write(P_CMD, 8'hA7);
        host_write(P_CMD, 8'h20);
        tick();
        peek(s); check(s & 8'h01, 8'h00, "R2 write while full dropped");
        host_write(P_CMD, 8'h20); tick();
        host_read(8'h67, "R7 A7 sets bit5");
        host_write(P_CMD, 8'hA8); tick();
        host_write(P_CMD, 8'h20); tick();
        host_read(8'h47, "R7 A8 clears bit5");

        // keyboard byte
        dev_send(1'b0, 8'h1C, 1'b1, "R9 kbd ready when empty");
        peek(s); tick(); peek(s2);
        check(s2, s, "R4 status read no side effect");
        check(s2 & 8'h21, 8'h01, "R4 output still full");
        check({6'd0, kbd_irq, mouse_irq}, 8'h02, "R10 kbd irq");
        dev_send(1'b1, 8'h33, 1'b0, "R9 not ready when full");
        host_read(8'h1C, "R8 kbd byte");
        check({6'd0, kbd_irq, mouse_irq}, 8'h00, "R10 irq drops after read");

        // mouse byte
        dev_send(1'b1, 8'hAA, 1'b1, "R9 mouse ready");
        peek(s); check(s & 8'h21, 8'h21, "R3 mouse full bit");
        check({6'd0, kbd_irq, mouse_irq}, 8'h01, "R10 mouse irq");
        host_read(8'hAA, "R8 mouse byte");
        peek(s); check(s & 8'h21, 8'h00, "R8 mouse full cleared");

        // mouse disabled
        host_write(P_CMD, 8'hA7); tick();
        dev_send(1'b1, 8'h55, 1'b0, "R9 mouse disabled");
        peek(s); check(s & 8'h01, 8'h00, "R9 disabled byte not taken");

        // error flags
        dev_timeout = 1; tick(); dev_timeout = 0;
        peek(s); check(s & 8'hC0, 8'h40, "R11 timeout set");
        tick();
        dev_parity = 1; tick(); dev_parity = 0;
        peek(s); check(s & 8'hC0, 8'hC0, "R11 flags held");
        host_read(8'hAA, "R8 stale byte on empty read");
        peek(s); check(s & 8'hC0, 8'h00, "R11 cleared by data read");

        // unknown command, unarmed data
        host_write(P_CMD, 8'hD4); tick();
        peek(s); check(s & 8'h03, 8'h00, "R12 unknown command no output");
        host_write(P_DATA, 8'h99); tick();
        host_write(P_CMD, 8'h20); tick();
        host_read(8'h67, "R12 config unchanged");

        // keyboard disable and irq disable
        host_write(P_CMD, 8'h60); tick();
        host_write(P_DATA, 8'h10); tick();
        dev_send(1'b0, 8'h11, 1'b0, "R9 kbd disabled");
        host_write(P_CMD, 8'h60); tick();
        host_write(P_DATA, 8'h00); tick();
        dev_send(1'b0, 8'h11, 1'b1, "R9 kbd enabled");
        check({7'd0, kbd_irq}, 8'h00, "R10 irq masked");
        host_read(8'h11, "R9 kbd byte after enable");

        kbd_inhibit_n = 0;
        peek(s); check(s & 8'h10, 8'h00, "R3 inhibit bit");
        tick();

        check(exp_q.size(), 0, "R8 scoreboard drained");
        summary();
    end

endmodule